// File: doc/BRIEF.md
# Banked TLB Register Access Port

This block is the register-side path into a TLB that software manages by hand. It holds a small file of special registers and a TLB array split into two banks. Each bank has four sets of sixteen entries, and each entry is a pair of 32-bit words: a high word carrying the virtual page number, and a low word carrying the valid bit and attributes. A 2-bit register-bank selector, driven by the surrounding processor, enables the TLB side effects and picks the bank. A selection register inside the special-register file names the set and the index.

Software loads an entry in two steps. A write to the high mirror register also copies its value into the cause register. A write to the low mirror register then stores the low word together with the current cause value into the selected entry. Overwriting an entry raises a one-cycle invalidate request for the page that entry held. Any read while a TLB bank is selected first refreshes both mirror registers from the selected entry, so software can read an entry back through the same registers. Reads return one cycle after the request.

Top module: `tlbp_port`

## Requirements
- R1: After reset every special register and every TLB entry reads as zero, and `flush_o` and `rd_valid_o` are low.
- R2: A write stores `wr_data_i` into special register `wr_addr_i`. A read raises `rd_valid_o` exactly one cycle after `rd_valid_i`, and `rd_data_o` then holds the register's value.
- R3: When the selector is 1 or 2, a write to the high mirror (address 6) also writes the same value into the cause register (address 12).
- R4: When the selector is 1 or 2, a write to the low mirror (address 5) stores the written word as the entry's low word and the cause register as the entry's high word. The entry is in bank selector−1, at set = selection register (address 2) bits [5:4] and index = bits [3:0]. Higher selection bits are ignored.
- R5: Each such low-mirror write raises `flush_o` for exactly one cycle, in the cycle after the write. The pulse carries the replaced entry's old high word bits [31:13] on `flush_vpn_o` and its old low word bit 3 on `flush_vld_o`.
- R6: When the selector is 1 or 2, any read first loads the selected entry's low word into address 5 and its high word into address 6. The read data reflects that load.
- R7: With selector 0 or 3, writes to addresses 5 and 6 only store the register: no entry changes, no flush pulse, and the cause register is unchanged. Reads do not reload the mirrors.
- R8: The two banks are independent. The same set and index in bank 1 and bank 2 name different entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srs_i | input | 2 | Register-bank selector; 1 and 2 pick TLB bank 0 and 1 |
| wr_valid_i | input | 1 | Special-register write strobe |
| wr_addr_i | input | 4 | Special-register write address |
| wr_data_i | input | 32 | Write data |
| rd_valid_i | input | 1 | Special-register read strobe |
| rd_addr_i | input | 4 | Special-register read address |
| rd_valid_o | output | 1 | Read data valid, one cycle after the read |
| rd_data_o | output | 32 | Read data |
| flush_o | output | 1 | One-cycle single-page invalidate request |
| flush_vpn_o | output | 19 | Virtual page number of the replaced entry |
| flush_vld_o | output | 1 | Valid bit of the replaced entry |

## Verification
The checks take for granted that a write and a read never arrive in the same cycle. Under that condition the mirror reload and the register write cannot compete for addresses 5 and 6. The stimulus keeps every access a single-cycle strobe followed by an idle cycle. It never issues both strobes together, and it changes the selector only between accesses. The cause checks also assume nothing writes address 12 in the same cycle as a high-mirror write. This always holds, because the block has only one write port.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } tlb_ent_t;
endpackage

// File: rtl/tlbp_decode.sv
module tlbp_decode #(
    parameter int NUM_BANKS = 2,
    parameter int NUM_SETS  = 4,
    parameter int NUM_IDX   = 16,
    parameter int SRS_W     = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int SET_W    = $clog2(NUM_SETS),
    localparam int IDX_W    = $clog2(NUM_IDX),
    localparam int SEL_W    = SET_W + IDX_W,
    localparam int ENT_W    = BANK_W + SEL_W
) (
    input  logic [SRS_W-1:0] srs_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             active_o,
    output logic [ENT_W-1:0] ent_o
);
    logic [SRS_W-1:0]  srs_m1;
    logic [BANK_W-1:0] bank;
    logic [SET_W-1:0]  set_no;
    logic [IDX_W-1:0]  idx_no;

    always_comb begin
        srs_m1   = srs_i - SRS_W'(1);
        bank     = srs_m1[BANK_W-1:0];
        set_no   = sel_i[SEL_W-1:IDX_W];
        idx_no   = sel_i[IDX_W-1:0];
        active_o = (srs_i != '0) && (int'(srs_i) <= NUM_BANKS);
        ent_o    = {bank, set_no, idx_no};
    end
endmodule

// File: rtl/tlbp_array.sv
module tlbp_array
    import tlbp_pkg::*;
#(
    parameter int NUM_ENT = 128,
    localparam int ENT_W  = $clog2(NUM_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [ENT_W-1:0] waddr_i,
    input  tlb_ent_t         wdata_i,
    input  logic [ENT_W-1:0] raddr_i,
    output tlb_ent_t         rdata_o
);
    typedef struct packed {
        tlb_ent_t [NUM_ENT-1:0] ent;
    } arr_t;

    arr_t arr_d, arr_q;

    always_comb begin
        arr_d = arr_q;
        if (we_i) begin
            arr_d.ent[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_q <= '0;
        end else begin
            arr_q <= arr_d;
        end
    end

    assign rdata_o = arr_q.ent[raddr_i];
endmodule

// File: rtl/tlbp_sreg.sv
module tlbp_sreg
    import tlbp_pkg::*;
#(
    parameter int NUM_SREG   = 16,
    parameter int SEL_ADDR   = 2,
    parameter int LO_ADDR    = 5,
    parameter int HI_ADDR    = 6,
    parameter int CAUSE_ADDR = 12,
    parameter int SEL_W      = 6,
    localparam int AW        = $clog2(NUM_SREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              rd_valid_i,
    input  logic [AW-1:0]     rd_addr_i,
    input  logic              active_i,
    input  tlb_ent_t          ent_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic [WORD_W-1:0] cause_o,
    output logic              rd_valid_o,
    output logic [WORD_W-1:0] rd_data_o
);
    localparam logic [AW-1:0] SEL_A   = AW'(SEL_ADDR);
    localparam logic [AW-1:0] LO_A    = AW'(LO_ADDR);
    localparam logic [AW-1:0] HI_A    = AW'(HI_ADDR);
    localparam logic [AW-1:0] CAUSE_A = AW'(CAUSE_ADDR);

    typedef struct packed {
        logic [NUM_SREG-1:0][WORD_W-1:0] file;
        logic                            rd_v;
        logic [WORD_W-1:0]               rd_d;
    } sreg_t;

    sreg_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.rd_v = rd_valid_i;
        if (rd_valid_i) begin
            if (active_i) begin
                s_d.file[LO_A] = ent_i.lo;
                s_d.file[HI_A] = ent_i.hi;
            end
            s_d.rd_d = s_d.file[rd_addr_i];
        end
        if (wr_valid_i) begin
            s_d.file[wr_addr_i] = wr_data_i;
            if (active_i && (wr_addr_i == HI_A)) begin
                s_d.file[CAUSE_A] = wr_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sel_o      = s_q.file[SEL_A][SEL_W-1:0];
    assign cause_o    = s_q.file[CAUSE_A];
    assign rd_valid_o = s_q.rd_v;
    assign rd_data_o  = s_q.rd_d;
endmodule

// File: rtl/tlbp_port.sv
module tlbp_port
    import tlbp_pkg::*;
#(
    parameter int NUM_BANKS  = 2,
    parameter int NUM_SETS   = 4,
    parameter int NUM_IDX    = 16,
    parameter int NUM_SREG   = 16,
    parameter int SRS_W      = 2,
    parameter int SEL_ADDR   = 2,
    parameter int LO_ADDR    = 5,
    parameter int HI_ADDR    = 6,
    parameter int CAUSE_ADDR = 12,
    parameter int VPN_LSB    = 13,
    parameter int VLD_BIT    = 3,
    localparam int AW        = $clog2(NUM_SREG),
    localparam int VPN_W     = WORD_W - VPN_LSB,
    localparam int SEL_W     = $clog2(NUM_SETS) + $clog2(NUM_IDX),
    localparam int NUM_ENT   = NUM_BANKS * NUM_SETS * NUM_IDX,
    localparam int ENT_W     = $clog2(NUM_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRS_W-1:0]  srs_i,
    input  logic              wr_valid_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              rd_valid_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic              rd_valid_o,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              flush_o,
    output logic [VPN_W-1:0]  flush_vpn_o,
    output logic              flush_vld_o
);
    localparam logic [AW-1:0] LO_A = AW'(LO_ADDR);

    typedef struct packed {
        logic             v;
        logic [VPN_W-1:0] vpn;
        logic             old_vld;
    } flush_t;

    logic              active;
    logic [ENT_W-1:0]  ent_idx;
    logic [SEL_W-1:0]  sel_field;
    logic [WORD_W-1:0] cause_w;
    tlb_ent_t          ent_old;
    tlb_ent_t          ent_new;
    logic              commit;
    flush_t            fl_d, fl_q;

    tlbp_decode #(
        .NUM_BANKS (NUM_BANKS),
        .NUM_SETS  (NUM_SETS),
        .NUM_IDX   (NUM_IDX),
        .SRS_W     (SRS_W)
    ) u_decode (
        .srs_i    (srs_i),
        .sel_i    (sel_field),
        .active_o (active),
        .ent_o    (ent_idx)
    );

    tlbp_sreg #(
        .NUM_SREG   (NUM_SREG),
        .SEL_ADDR   (SEL_ADDR),
        .LO_ADDR    (LO_ADDR),
        .HI_ADDR    (HI_ADDR),
        .CAUSE_ADDR (CAUSE_ADDR),
        .SEL_W      (SEL_W)
    ) u_sreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid_i (wr_valid_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_valid_i (rd_valid_i),
        .rd_addr_i  (rd_addr_i),
        .active_i   (active),
        .ent_i      (ent_old),
        .sel_o      (sel_field),
        .cause_o    (cause_w),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

    tlbp_array #(
        .NUM_ENT (NUM_ENT)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (commit),
        .waddr_i (ent_idx),
        .wdata_i (ent_new),
        .raddr_i (ent_idx),
        .rdata_o (ent_old)
    );

    always_comb begin
        commit     = wr_valid_i && active && (wr_addr_i == LO_A);
        ent_new.hi = cause_w;
        ent_new.lo = wr_data_i;
        fl_d       = fl_q;
        fl_d.v     = commit;
        if (commit) begin
            fl_d.vpn     = ent_old.hi[WORD_W-1:VPN_LSB];
            fl_d.old_vld = ent_old.lo[VLD_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flush_o     = fl_q.v;
    assign flush_vpn_o = fl_q.vpn;
    assign flush_vld_o = fl_q.old_vld;
endmodule

// File: rtl/tlbp_port_chk.sv
module tlbp_port_chk #(
    parameter int NUM_BANKS = 2,
    parameter int SRS_W     = 2,
    parameter int AW        = 4,
    parameter int LO_ADDR   = 5,
    parameter int HI_ADDR   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SRS_W-1:0] srs_i,
    input logic             wr_valid_i,
    input logic [AW-1:0]    wr_addr_i,
    input logic [31:0]      wr_data_i,
    input logic             rd_valid_i,
    input logic             rd_valid_o,
    input logic             flush_o,
    input logic [31:0]      cause_w
);
    logic tlb_on;
    logic lo_wr;
    logic hi_wr;

    assign tlb_on = (int'(srs_i) >= 1) && (int'(srs_i) <= NUM_BANKS);
    assign lo_wr  = wr_valid_i && (int'(wr_addr_i) == LO_ADDR);
    assign hi_wr  = wr_valid_i && (int'(wr_addr_i) == HI_ADDR);

    AST_FLUSH_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && tlb_on) |=> flush_o); // R5

    AST_NO_STRAY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_wr && tlb_on) |=> !flush_o); // R7

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_i |=> rd_valid_o); // R2

    AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_i |=> !rd_valid_o); // R2

    AST_CAUSE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && tlb_on) |=> (cause_w == $past(wr_data_i))); // R3

    AST_CAUSE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && !tlb_on) |=> $stable(cause_w)); // R7
endmodule

bind tlbp_port tlbp_port_chk #(
    .NUM_BANKS (NUM_BANKS),
    .SRS_W     (SRS_W),
    .AW        (AW),
    .LO_ADDR   (LO_ADDR),
    .HI_ADDR   (HI_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .srs_i      (srs_i),
    .wr_valid_i (wr_valid_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_valid_i (rd_valid_i),
    .rd_valid_o (rd_valid_o),
    .flush_o    (flush_o),
    .cause_w    (cause_w)
);

// File: tb/tlbp_port_test.sv
module tlbp_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  srs = 2'd0;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_valid = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic        rd_valid_o;
    logic [31:0] rd_data_o;
    logic        flush_o;
    logic [18:0] flush_vpn_o;
    logic        flush_vld_o;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    logic [31:0] m_sreg [0:15];
    logic [31:0] m_hi [0:1][0:3][0:15];
    logic [31:0] m_lo [0:1][0:3][0:15];
    logic        e_fl = 1'b0;
    logic [18:0] e_vpn = '0;
    logic        e_fv = 1'b0;
    logic        e_rv = 1'b0;
    logic [31:0] e_rd = '0;
    bit          cmp_en = 1'b0;

    always #4 clk = ~clk;

    tlbp_port uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .srs_i       (srs),
        .wr_valid_i  (wr_valid),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_valid_i  (rd_valid),
        .rd_addr_i   (rd_addr),
        .rd_valid_o  (rd_valid_o),
        .rd_data_o   (rd_data_o),
        .flush_o     (flush_o),
        .flush_vpn_o (flush_vpn_o),
        .flush_vld_o (flush_vld_o)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
        end
    endtask

    // Behavioural reference, stepped on each rising edge.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_sreg[i] = '0;
            for (int b = 0; b < 2; b++)
                for (int s = 0; s < 4; s++)
                    for (int x = 0; x < 16; x++) begin
                        m_hi[b][s][x] = '0;
                        m_lo[b][s][x] = '0;
                    end
            e_fl = 1'b0;
            e_rv = 1'b0;
        end else begin
            bit on;
            int b, s, x;
            on = (srs == 2'd1) || (srs == 2'd2);
            b  = int'(srs) - 1;
            s  = int'(m_sreg[2][5:4]);
            x  = int'(m_sreg[2][3:0]);
            e_fl = 1'b0;
            e_rv = rd_valid;
            if (rd_valid) begin
                if (on) begin
                    m_sreg[5] = m_lo[b][s][x];
                    m_sreg[6] = m_hi[b][s][x];
                end
                e_rd = m_sreg[rd_addr];
            end
            if (wr_valid) begin
                if (on && wr_addr == 4'd5) begin
                    e_fl  = 1'b1;
                    e_vpn = m_hi[b][s][x][31:13];
                    e_fv  = m_lo[b][s][x][3];
                    m_hi[b][s][x] = m_sreg[12];
                    m_lo[b][s][x] = wr_data;
                end
                m_sreg[wr_addr] = wr_data;
                if (on && wr_addr == 4'd6) m_sreg[12] = wr_data;
            end
        end
    end

    // Compare with the reference on every clock, away from the edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(flush_o == e_fl, "flush", 32'(flush_o), 32'(e_fl));
            if (e_fl) begin
                chk(flush_vpn_o == e_vpn, "flush_vpn", 32'(flush_vpn_o), 32'(e_vpn));
                chk(flush_vld_o == e_fv, "flush_vld", 32'(flush_vld_o), 32'(e_fv));
            end
            chk(rd_valid_o == e_rv, "rd_valid", 32'(rd_valid_o), 32'(e_rv));
            if (e_rv) chk(rd_data_o == e_rd, "rd_data", rd_data_o, e_rd);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string t);
        @(negedge clk);
        cur_tag  = t;
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string t);
        @(negedge clk);
        cur_tag  = t;
        rd_valid = 1'b1;
        rd_addr  = a;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic bank(input logic [1:0] v);
        @(negedge clk);
        srs = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        cur_tag = "R1";
        chk(flush_o == 1'b0, "reset flush", 32'(flush_o), 0);
        chk(rd_valid_o == 1'b0, "reset rd_valid", 32'(rd_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;

        // R1: registers and entries zero after reset
        rd(4'd5, "R1");
        rd(4'd12, "R1");
        bank(2'd1);
        rd(4'd6, "R1");
        rd(4'd5, "R1");

        // R2: plain store and read, no bank selected
        bank(2'd0);
        wr(4'd9, 32'h1357_9BDF, "R2");
        rd(4'd9, "R2");
        wr(4'd0, 32'hFFFF_0001, "R2");
        rd(4'd0, "R2");

        // R3: high mirror write copies into cause
        bank(2'd1);
        wr(4'd2, 32'h0000_0025, "R4");
        wr(4'd6, 32'h1234_6000, "R3");
        rd(4'd12, "R3");

        // R4/R5: commit into empty entry, flush of old page 0
        wr(4'd5, 32'h0000_0008, "R4");
        // R6: mirror reload on read
        wr(4'd6, 32'hDEAD_0000, "R6");
        rd(4'd6, "R6");
        rd(4'd5, "R6");
        rd(4'd9, "R6");

        // R5: overwrite a valid entry, old page 0x091A3 flushed
        wr(4'd6, 32'h0F0F_2000, "R5");
        wr(4'd5, 32'h0000_0001, "R5");
        rd(4'd6, "R5");

        // R8: second bank independent
        bank(2'd2);
        rd(4'd5, "R8");
        wr(4'd6, 32'hAAAA_E000, "R8");
        wr(4'd5, 32'h0000_005A, "R8");
        bank(2'd1);
        rd(4'd5, "R8");
        bank(2'd2);
        rd(4'd6, "R8");

        // R7: selector 0 and 3 give no side effects
        bank(2'd0);
        wr(4'd5, 32'h0000_0077, "R7");
        rd(4'd5, "R7");
        wr(4'd6, 32'h1111_0000, "R7");
        rd(4'd12, "R7");
        bank(2'd3);
        wr(4'd5, 32'h0000_0099, "R7");
        rd(4'd5, "R7");
        rd(4'd6, "R7");

        // R4: spread of sets and indices, upper select bits set
        bank(2'd1);
        for (int k = 0; k < 8; k++) begin
            wr(4'd2, 32'hFFFF_FF00 | 32'((k % 4) * 16 + (k * 5) % 16), "R4");
            wr(4'd6, 32'h0040_2000 * (k + 1), "R4");
            wr(4'd5, 32'h0000_0008 | 32'(k << 8), "R4");
        end
        for (int k = 0; k < 8; k++) begin
            wr(4'd2, 32'((k % 4) * 16 + (k * 5) % 16), "R4");
            rd(4'd5, "R4");
            rd(4'd6, "R4");
            wr(4'd5, 32'h0000_0000, "R5");
        end

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule